// File: doc/BRIEF.md
# E1/T1 Transmit Frame Position Marker Pin

This block follows the bit position of a serial transmit stream in E1 or T1 framing. It drives one multipurpose pin whose job is picked by a 4-bit function code. The pin can pulse at the start of each multiframe, or mark the signaling slots, the robbed bits, or the spare and data-link bits. It can also echo the transmit clock. As an input, it can request a line tristate or serve as a general-purpose input that is captured into a status bit.

Two counters track the position: a bit counter within the frame and a frame counter within the multiframe. An E1 frame holds 256 bits in 32 slots of 8 bits, and an E1 multiframe holds 16 frames. A T1 frame holds 193 bits: the F bit, then 24 channels of 8 bits. A T1 multiframe holds 24 frames in extended-superframe mode and 12 frames otherwise.

Every marker is registered and is valid in the same bit period as the bit it marks. A synchronous reset restarts the count at bit 0 of frame 0.

Top module: `tx_marker_pin`

## Requirements
- R1: After a synchronous reset, the position is bit 0 of frame 0, the multiframe marker is high in that bit period, and `gpi_status` is 0.
- R2: With `fsel`=0100, `pin_out` is high for exactly one bit period: bit 0 of frame 0. The repetition period is 4096 bits in E1, 4632 bits in T1 extended-superframe mode and 2316 bits in T1 otherwise.
- R3: In E1 with `fsel`=0101, `pin_out` is high for all 8 bits of slot n (bits 8n to 8n+7) when `ts_mask[n]` is 1.
- R4: In T1 with `fsel`=0101 and `cas_rb_en`=0, `pin_out` is high for bits 1+8k to 8+8k (channel k+1) when `ts_mask[k]` is 1, for k from 0 to 23. The F bit (bit 0) is never marked, and `ts_mask[31:24]` has no effect.
- R5: In T1 with `fsel`=0101 and `cas_rb_en`=1, `pin_out` marks only the last bit of each channel (bits 8, 16, ..., 192), and only in frames 5, 11, 17 and 23 (counting from 0). `ts_mask` is ignored in this mode.
- R6: In E1 with `fsel`=0110, `pin_out` is high at bit 3+j of slot 0 of odd-numbered frames when `sa_en[j]` is 1. Bit 3 carries spare bit 4 and bit 7 carries spare bit 8. Nothing else is marked.
- R7: In T1 with `fsel`=0110, `pin_out` marks bit 0 of every even-numbered frame when `esf_en`=1, which gives one mark every 386 bits. When `esf_en`=0, `pin_out` stays low.
- R8: `pin_oe` is 1 only for `fsel` 0100 to 0111. For `fsel`=0111, `pin_out` follows `clk`. For every other code that does not drive the pin, `pin_out` is 0.
- R9: `line_tristate` equals `tri_reg` OR (`fsel`=1000 AND `pin_in`), with no delay.
- R10: While `fsel`=1001, `gpi_status` takes the value of `pin_in` at each clock edge. Under any other code it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous reset, active high |
| t1_mode | input | 1 | 1 selects T1 framing, 0 selects E1 |
| esf_en | input | 1 | T1 extended-superframe mode |
| cas_rb_en | input | 1 | T1 robbed-bit signaling marking |
| tri_reg | input | 1 | Register tristate request |
| fsel | input | 4 | Pin function code |
| ts_mask | input | 32 | Per-slot/channel signaling mask |
| sa_en | input | 5 | Spare-bit enables, bit 0 = spare bit 4 |
| pin_in | input | 1 | Level seen on the pin when used as input |
| pin_out | output | 1 | Value driven on the pin |
| pin_oe | output | 1 | Pin output enable |
| line_tristate | output | 1 | Transmit line tristate request |
| gpi_status | output | 1 | Captured general-purpose input level |

## Verification
The position of a marker output is due in the bit period after the clock edge that sees reset or the previous position, so bit period n after reset shows position n. The bench samples each period at the falling edge and compares it with a position computed arithmetically from n. `line_tristate`, `pin_oe` and the mode-0111 clock echo are combinational, so the bench checks them a moment after it changes an input. The clock echo is checked on both clock levels. `gpi_status` is due one edge after `pin_in` changes and is sampled at the falling edge that follows.

// File: rtl/tx_marker_pin.sv
module tx_marker_pin (
  input  logic        clk,
  input  logic        rst,
  input  logic        t1_mode,
  input  logic        esf_en,
  input  logic        cas_rb_en,
  input  logic        tri_reg,
  input  logic [3:0]  fsel,
  input  logic [31:0] ts_mask,
  input  logic [4:0]  sa_en,
  input  logic        pin_in,
  output logic        pin_out,
  output logic        pin_oe,
  output logic        line_tristate,
  output logic        gpi_status
);
  localparam logic [7:0] E1_LAST_BIT = 8'd255;
  localparam logic [7:0] T1_LAST_BIT = 8'd192;
  localparam logic [4:0] E1_LAST_FRM = 5'd15;
  localparam logic [4:0] ESF_LAST_FRM = 5'd23;
  localparam logic [4:0] SF_LAST_FRM = 5'd11;
  localparam logic [4:0] T1_CHANNELS = 5'd24;

  logic [7:0] bit_q, bit_n;
  logic [4:0] frm_q, frm_n;
  logic       mfb_q, sig_q, dl_q, gpi_q;

  wire [7:0] bit_last = t1_mode ? T1_LAST_BIT : E1_LAST_BIT;
  wire [4:0] frm_last = t1_mode ? (esf_en ? ESF_LAST_FRM : SF_LAST_FRM) : E1_LAST_FRM;

  always_comb begin
    bit_n = bit_q + 8'd1;
    frm_n = frm_q;
    if (bit_q >= bit_last) begin
      bit_n = 8'd0;
      frm_n = (frm_q >= frm_last) ? 5'd0 : frm_q + 5'd1;
    end
    if (rst) begin
      bit_n = 8'd0;
      frm_n = 5'd0;
    end
  end

  wire [7:0] ch_off   = bit_n - 8'd1;
  wire [4:0] t1_ch    = ch_off[7:3];
  wire       rb_frame = (frm_n == 5'd5) || (frm_n == 5'd11) ||
                        (frm_n == 5'd17) || (frm_n == 5'd23);
  wire [7:0] sa_pos   = {sa_en, 3'b000};

  wire mfb_d  = (bit_n == 8'd0) && (frm_n == 5'd0);
  wire sig_e1 = ts_mask[bit_n[7:3]];
  wire sig_t1 = (bit_n != 8'd0) &&
                (cas_rb_en ? (ch_off[2:0] == 3'd7) && rb_frame
                           : (t1_ch < T1_CHANNELS) && ts_mask[t1_ch]);
  wire dl_e1  = (bit_n[7:3] == 5'd0) && frm_n[0] && sa_pos[bit_n[2:0]];
  wire dl_t1  = esf_en && (bit_n == 8'd0) && !frm_n[0];

  always_ff @(posedge clk) begin
    bit_q <= bit_n;
    frm_q <= frm_n;
    mfb_q <= mfb_d;
    sig_q <= t1_mode ? sig_t1 : sig_e1;
    dl_q  <= t1_mode ? dl_t1 : dl_e1;
    if (rst)                 gpi_q <= 1'b0;
    else if (fsel == 4'b1001) gpi_q <= pin_in;
  end

  always_comb begin
    case (fsel)
      4'b0100: pin_out = mfb_q;
      4'b0101: pin_out = sig_q;
      4'b0110: pin_out = dl_q;
      4'b0111: pin_out = clk;
      default: pin_out = 1'b0;
    endcase
  end

  assign pin_oe        = (fsel[3:2] == 2'b01);
  assign line_tristate = tri_reg | ((fsel == 4'b1000) & pin_in);
  assign gpi_status    = gpi_q;
endmodule

module tx_marker_pin_chk (
  input logic        clk,
  input logic        rst,
  input logic        t1_mode,
  input logic        esf_en,
  input logic        tri_reg,
  input logic [3:0]  fsel,
  input logic        pin_in,
  input logic        pin_out,
  input logic        pin_oe,
  input logic        line_tristate,
  input logic        gpi_status
);
  AST_MFB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (fsel == 4'b0100 && pin_out) |=> (fsel != 4'b0100 || !pin_out)); // R2
  AST_DL_SF_LOW: assert property (@(posedge clk) disable iff (rst)
    (fsel == 4'b0110 && t1_mode && !esf_en && $past(t1_mode && !esf_en)) |-> !pin_out); // R7
  AST_IDLE_PIN: assert property (@(posedge clk) disable iff (rst)
    (fsel[3:2] != 2'b01) |-> (!pin_oe && !pin_out)); // R8
  AST_TRI_REG: assert property (@(posedge clk) disable iff (rst)
    tri_reg |-> line_tristate); // R9
  AST_TRI_PIN: assert property (@(posedge clk) disable iff (rst)
    (fsel == 4'b1000 && pin_in) |-> line_tristate); // R9
  AST_GPI_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (fsel == 4'b1001) |=> (gpi_status == $past(pin_in))); // R10
  AST_GPI_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fsel != 4'b1001) |=> $stable(gpi_status)); // R10
endmodule

bind tx_marker_pin tx_marker_pin_chk chk (
  .clk(clk), .rst(rst), .t1_mode(t1_mode), .esf_en(esf_en), .tri_reg(tri_reg),
  .fsel(fsel), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
  .line_tristate(line_tristate), .gpi_status(gpi_status)
);

// File: tb/tx_marker_pin_test.sv
module tx_marker_pin_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic t1_mode = 1'b0, esf_en = 1'b0, cas_rb_en = 1'b0, tri_reg = 1'b0, pin_in = 1'b0;
  logic [3:0]  fsel = 4'b0000;
  logic [31:0] ts_mask = '0;
  logic [4:0]  sa_en = '0;
  logic pin_out, pin_oe, line_tristate, gpi_status;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tx_marker_pin uut (
    .clk(clk), .rst(rst), .t1_mode(t1_mode), .esf_en(esf_en), .cas_rb_en(cas_rb_en),
    .tri_reg(tri_reg), .fsel(fsel), .ts_mask(ts_mask), .sa_en(sa_en), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .line_tristate(line_tristate), .gpi_status(gpi_status)
  );

  task automatic chk(string tag, logic act, logic exp, int n);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s step %0d: got %b expected %b", tag, n, act, exp);
    end
  endtask

  function automatic logic expect_mark(int n, int which, bit t1, bit esf, bit cas,
                                       logic [31:0] m, logic [4:0] sa);
    int flen = t1 ? 193 : 256;
    int mfl  = t1 ? (esf ? 24 : 12) : 16;
    int b    = n % flen;
    int f    = (n / flen) % mfl;
    logic r  = 1'b0;
    if (which == 0) r = (b == 0 && f == 0);
    else if (which == 1) begin
      if (!t1) r = m[b / 8];
      else if (b > 0) begin
        if (cas) r = ((b - 1) % 8 == 7) && (f % 6 == 5);
        else if ((b - 1) / 8 < 24) r = m[(b - 1) / 8];
      end
    end else begin
      if (!t1) begin
        if (b >= 3 && b <= 7 && f % 2 == 1) r = sa[b - 3];
      end else r = esf && b == 0 && f % 2 == 0;
    end
    return r;
  endfunction

  task automatic run(string tag, bit t1, bit esf, bit cas, logic [3:0] sel,
                     logic [31:0] m, logic [4:0] sa, int cycles, int which);
    @(negedge clk);
    t1_mode = t1; esf_en = esf; cas_rb_en = cas; fsel = sel; ts_mask = m; sa_en = sa;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int n = 0; n < cycles; n++) begin
      chk(tag, pin_out, expect_mark(n, which, t1, esf, cas, m, sa), n);
      if (n == 0) chk("R8", pin_oe, 1'b1, n);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1", gpi_status, 1'b0, 0);
    // R1 / R2 multiframe pulses
    run("R2", 0, 0, 0, 4'b0100, '0, '0, 4096 + 300, 0);
    run("R2", 1, 1, 0, 4'b0100, '0, '0, 4632 + 200, 0);
    run("R2", 1, 0, 0, 4'b0100, '0, '0, 2316 + 200, 0);
    // R3 E1 signaling slots
    run("R3", 0, 0, 0, 4'b0101, 32'h8000_0001, '0, 512, 1);
    run("R3", 0, 0, 0, 4'b0101, 32'hA5A5_3C0F, '0, 512, 1);
    // R4 T1 channels, upper mask bits ignored
    run("R4", 1, 1, 0, 4'b0101, 32'hFF80_0F81, '0, 386, 1);
    run("R4", 1, 0, 0, 4'b0101, 32'h00FF_FFFF, '0, 386, 1);
    // R5 robbed bits, mask ignored
    run("R5", 1, 1, 1, 4'b0101, 32'h0000_0000, '0, 4632, 1);
    run("R5", 1, 1, 1, 4'b0101, 32'hFFFF_FFFF, '0, 4632, 1);
    // R6 E1 spare bits
    run("R6", 0, 0, 0, 4'b0110, '0, 5'b10110, 1024, 2);
    run("R6", 0, 0, 0, 4'b0110, '0, 5'b11111, 1024, 2);
    run("R6", 0, 0, 0, 4'b0110, '0, 5'b00001, 1024, 2);
    // R7 T1 data link
    run("R7", 1, 1, 0, 4'b0110, '0, 5'b11111, 4632, 2);
    run("R7", 1, 0, 0, 4'b0110, '0, 5'b11111, 2316, 2);
    // R8 pin direction and mux
    begin
      logic [3:0] idle [5] = '{4'b0000, 4'b0011, 4'b1000, 4'b1001, 4'b1111};
      for (int i = 0; i < 5; i++) begin
        @(negedge clk); fsel = idle[i]; #1;
        chk("R8", pin_oe, 1'b0, i);
        chk("R8", pin_out, 1'b0, i);
      end
    end
    @(negedge clk); fsel = 4'b0111; #1;
    chk("R8", pin_oe, 1'b1, 0);
    chk("R8", pin_out, 1'b0, 0);
    @(posedge clk); #1;
    chk("R8", pin_out, 1'b1, 1);
    // R9 tristate request
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      tri_reg = i[0]; pin_in = i[1]; fsel = i[2] ? 4'b1000 : 4'b0000; #1;
      chk("R9", line_tristate, i[0] | (i[1] & i[2]), i);
    end
    // R10 general-purpose input capture
    @(negedge clk); tri_reg = 1'b0; fsel = 4'b0000; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1", gpi_status, 1'b0, 1);
    fsel = 4'b1001; pin_in = 1'b1;
    @(negedge clk); chk("R10", gpi_status, 1'b1, 0);
    pin_in = 1'b0;
    @(negedge clk); chk("R10", gpi_status, 1'b0, 1);
    pin_in = 1'b1;
    @(negedge clk); chk("R10", gpi_status, 1'b1, 2);
    fsel = 4'b0000; pin_in = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R10", gpi_status, 1'b1, 3 + i);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule